// File: doc/BRIEF.md
# Retention RAM Row-Group Power Gating Controller

This controller drives the footer switches of a retention RAM whose rows are grouped in pairs, one switch per pair. While the chip is running, every footer is on, the RAM peripherals (decoders and read/write buffers) are powered, and accesses are allowed. On a standby request, the controller takes one snapshot of the row occupancy vector. From that snapshot it keeps on only the footers whose row pair holds live data. It also gates the peripherals for the whole standby period. The RAM cells themselves are never switched off as a whole, because their contents must be retained.

A wake event turns every footer and the peripheral supply back on in the same cycle. A ready flag then stays low for a settle time, given in cycles, which software can set. If a standby request arrives while a RAM access is still in flight, it is remembered and takes effect once the access finishes. A count of enabled footers is provided for test observation.

Top module: `pg_rowgate_ctrl`

## Requirements
- R1: After reset every footer enable is 1, the peripheral enable is 1, the ready flag is 1 and the footer count equals the number of groups (26 by default).
- R2: On standby entry, the occupancy vector (bit i = row i, 1 meaning in use) is sampled. Footer k (bit k of the footer output) drives rows 2k and 2k+1. From the cycle after the entry edge, footer k is 1 exactly when either of those bits was 1.
- R3: Throughout standby the peripheral enable and the ready flag are 0.
- R4: Changes on the occupancy input during standby have no effect on the footer enables.
- R5: A standby request, whether held or a single-cycle pulse, made while the access-busy input is 1 leaves all outputs in the running state. Standby is entered at the first edge at which access-busy is 0, and the occupancy is sampled at that edge.
- R6: At the edge after a wake event in standby, all footers and the peripheral enable are 1, and ready is still 0.
- R7: With settle value S sampled at the wake edge, ready stays 0 for S further edges and becomes 1 at the (S+1)th edge after the footers turn on.
- R8: The footer count output always equals the number of footer enables that are 1.
- R9: A wake event while running and a standby request while waking are both ignored, and neither is remembered.
- R10: Entering standby with no rows in use turns every footer off and gives a footer count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| used_rows | input | ROWS | Row occupancy, 1 = row holds live data |
| access_busy | input | 1 | A RAM access is in flight |
| sleep_req | input | 1 | Standby request |
| wake_evt | input | 1 | Wake event |
| settle_cycles | input | SETTLE_W | Settle delay before ready after wakeup |
| footer_en | output | GROUPS | Footer switch enables, one per row group |
| periph_en | output | 1 | RAM peripheral power enable |
| mem_ready | output | 1 | RAM access allowed |
| footer_on_cnt | output | CNT_W | Number of footers enabled |

## Verification
The hardest situation to reach from the ports is a standby request that is held off by a busy access. Here the occupancy must be captured at the release edge, not at the request edge. The bench pulses the request while busy is high, changes the occupancy vector before releasing busy, and checks that the footers reflect the later vector. The bench also sweeps each row of each group one at a time, and it sweeps every settle value across a full wake sequence.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_RUN  = 2'd0,
    PG_STBY = 2'd1,
    PG_WAKE = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pg_group_or.sv
module pg_group_or #(
  parameter int ROWS     = 52,
  parameter int GRP_ROWS = 2,
  parameter int GROUPS   = (ROWS + GRP_ROWS - 1) / GRP_ROWS
) (
  input  logic [ROWS-1:0]   rows,
  output logic [GROUPS-1:0] grp
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int r = 0; r < GRP_ROWS; r++) begin
        if (g * GRP_ROWS + r < ROWS) acc = acc | rows[g * GRP_ROWS + r];
      end
    end
    assign grp[g] = acc;
  end
endmodule

// File: rtl/pg_popcnt.sv
module pg_popcnt #(
  parameter int N = 26,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + W'(vec[i]);
  end
endmodule

// File: rtl/pg_settle_timer.sv
module pg_settle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pg_rowgate_ctrl.sv
module pg_rowgate_ctrl #(
  parameter int ROWS     = 52,
  parameter int GRP_ROWS = 2,
  parameter int SETTLE_W = 4,
  localparam int GROUPS  = (ROWS + GRP_ROWS - 1) / GRP_ROWS,
  localparam int CNT_W   = $clog2(GROUPS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ROWS-1:0]     used_rows,
  input  logic                access_busy,
  input  logic                sleep_req,
  input  logic                wake_evt,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [GROUPS-1:0]   footer_en,
  output logic                periph_en,
  output logic                mem_ready,
  output logic [CNT_W-1:0]    footer_on_cnt
);
  import pg_pkg::*;

  pg_state_e st;
  logic pend;
  logic [GROUPS-1:0] grp_used, footer_nxt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic go_sleep, go_wake, tmr_done, wake_done;

  pg_group_or #(.ROWS(ROWS), .GRP_ROWS(GRP_ROWS), .GROUPS(GROUPS)) u_grp (
    .rows(used_rows), .grp(grp_used)
  );

  assign go_sleep  = (st == PG_RUN) && (sleep_req || pend) && !access_busy;
  assign go_wake   = (st == PG_STBY) && wake_evt;
  assign wake_done = (st == PG_WAKE) && tmr_done;

  pg_settle_timer #(.W(SETTLE_W)) u_tmr (
    .clk(clk), .rst(rst), .load(go_wake), .load_val(settle_cycles),
    .run(st == PG_WAKE), .done(tmr_done)
  );

  always_comb begin
    footer_nxt = footer_en;
    if (go_sleep)     footer_nxt = grp_used;
    else if (go_wake) footer_nxt = '1;
  end

  pg_popcnt #(.N(GROUPS), .W(CNT_W)) u_cnt (.vec(footer_nxt), .cnt(cnt_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= PG_RUN;
      pend          <= 1'b0;
      footer_en     <= '1;
      periph_en     <= 1'b1;
      mem_ready     <= 1'b1;
      footer_on_cnt <= CNT_W'(GROUPS);
    end else begin
      footer_en     <= footer_nxt;
      footer_on_cnt <= cnt_nxt;
      if (st == PG_RUN) pend <= go_sleep ? 1'b0 : (pend | sleep_req);
      else              pend <= 1'b0;
      if (go_sleep) begin
        st        <= PG_STBY;
        periph_en <= 1'b0;
        mem_ready <= 1'b0;
      end else if (go_wake) begin
        st        <= PG_WAKE;
        periph_en <= 1'b1;
      end else if (wake_done) begin
        st        <= PG_RUN;
        mem_ready <= 1'b1;
      end
    end
  end

  p_periph_off_r3: assert property (@(posedge clk) disable iff (rst)
    (st == PG_STBY) |-> (!periph_en && !mem_ready));

  p_hold_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (st == PG_STBY && !wake_evt) |=> $stable(footer_en));

  p_defer_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (st == PG_RUN && access_busy) |=> (st == PG_RUN && mem_ready));

  p_wake_on_r6: assert property (@(posedge clk) disable iff (rst)
    (st == PG_STBY && wake_evt) |=> ((&footer_en) && periph_en && !mem_ready));

  p_ready_powered_r7: assert property (@(posedge clk) disable iff (rst)
    mem_ready |-> ((&footer_en) && periph_en));

  p_count_match_r8: assert property (@(posedge clk) disable iff (rst)
    footer_on_cnt == CNT_W'($countones(footer_en)));

  p_no_wake_run_r9: assert property (@(posedge clk) disable iff (rst)
    (st == PG_RUN && !go_sleep) |=> (st == PG_RUN));
endmodule

// File: tb/sim_pg_rowgate_ctrl.sv
module sim_pg_rowgate_ctrl;
  localparam int ROWS = 52;
  localparam int GR   = 26;
  localparam int SW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ROWS-1:0] used_rows = '0;
  logic access_busy = 1'b0, sleep_req = 1'b0, wake_evt = 1'b0;
  logic [SW-1:0] settle_cycles = '0;
  logic [GR-1:0] footer_en;
  logic periph_en, mem_ready;
  logic [4:0] footer_on_cnt;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  pg_rowgate_ctrl #(.ROWS(ROWS), .GRP_ROWS(2), .SETTLE_W(SW)) u0 (
    .clk(clk), .rst(rst), .used_rows(used_rows), .access_busy(access_busy),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .settle_cycles(settle_cycles),
    .footer_en(footer_en), .periph_en(periph_en), .mem_ready(mem_ready),
    .footer_on_cnt(footer_on_cnt)
  );

  function automatic logic [GR-1:0] exp_mask(input logic [ROWS-1:0] p);
    logic [GR-1:0] m;
    for (int k = 0; k < GR; k++) m[k] = p[2*k] | p[2*k+1];
    return m;
  endfunction

  function automatic int ones(input logic [GR-1:0] m);
    int n = 0;
    for (int k = 0; k < GR; k++) n += int'(m[k]);
    return n;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter(input logic [ROWS-1:0] p);
    used_rows = p;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R2 mask", 64'(footer_en), 64'(exp_mask(p)));
    chk("R3 periph", 64'({periph_en, mem_ready}), 64'(0));
    chk("R8 count", 64'(footer_on_cnt), 64'(ones(exp_mask(p))));
  endtask

  task automatic wake(input int s);
    settle_cycles = SW'(s);
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    chk("R6 all on", 64'({footer_en, periph_en, mem_ready}), 64'({{GR{1'b1}}, 2'b10}));
    chk("R8 count wake", 64'(footer_on_cnt), 64'(GR));
    for (int i = 1; i <= s; i++) begin
      step();
      chk("R7 not ready", 64'(mem_ready), 64'(0));
    end
    step();
    chk("R7 ready", 64'(mem_ready), 64'(1));
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset", 64'({footer_en, periph_en, mem_ready}), 64'({{GR{1'b1}}, 2'b11}));
    chk("R1 count", 64'(footer_on_cnt), 64'(GR));

    // R10 all rows free
    enter('0);
    chk("R10 all off", 64'(footer_en), 64'(0));
    wake(0);

    // R2 each row of each group alone, then both rows
    for (int k = 0; k < GR; k++) begin
      for (int v = 1; v < 4; v++) begin
        logic [ROWS-1:0] p;
        p = '0;
        p[2*k]   = v[0];
        p[2*k+1] = v[1];
        enter(p);
        wake(k % 3);
      end
    end

    // R2 / R4 random patterns, occupancy changes ignored in standby
    for (int t = 0; t < 40; t++) begin
      logic [ROWS-1:0] p;
      logic [GR-1:0] held;
      p = {$urandom, $urandom};
      enter(p);
      held = footer_en;
      used_rows = ~p;
      step();
      used_rows = '1;
      step();
      chk("R4 held", 64'(footer_en), 64'(held));
      chk("R3 standby", 64'({periph_en, mem_ready}), 64'(0));
      wake(t % 5);
    end

    // R7 settle sweep
    for (int s = 0; s < (1 << SW); s++) begin
      enter({ROWS{1'b1}});
      wake(s);
    end

    // R5 deferred request, occupancy sampled at release
    access_busy = 1'b1;
    used_rows = 52'h0000_0000_0000_3;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R5 deferred", 64'({footer_en, periph_en, mem_ready}), 64'({{GR{1'b1}}, 2'b11}));
    end
    used_rows = 52'h8_0000_0000_0000;
    access_busy = 1'b0;
    step();
    chk("R5 entered", 64'(footer_en), 64'(26'h200_0000));
    chk("R5 periph", 64'(periph_en), 64'(0));
    wake(2);

    // R9 wake while running ignored
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    step();
    chk("R9 wake ignored", 64'({footer_en, periph_en, mem_ready}), 64'({{GR{1'b1}}, 2'b11}));

    // R9 request while waking ignored, not remembered
    enter('0);
    settle_cycles = 4'd5;
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    for (int i = 0; i < 8; i++) step();
    chk("R9 req ignored", 64'({footer_en, periph_en, mem_ready}), 64'({{GR{1'b1}}, 2'b11}));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule